// File: doc/BRIEF.md
# CAN Fault-Confinement State Tracker

This block follows a CAN node's fault-confinement state. The bit-level protocol engine sends it single-cycle pulses: one for a frame sent without error, one for a frame received without error, and one for each detected bus error. Each error pulse carries a 3-bit error code and a flag that says whether the transmitter or the receiver side saw the error. From these pulses the block keeps a transmit error count and a receive error count. It derives the warning, passive and bus-off flags from the counts and records the code of the latest bus event.

Software sees the state through two read-only outputs: an 8-bit status word and a 16-bit counter word. A small write port lets software clear the sticky success flags. The same port can load the "unused" sentinel into the error-code field, so software can later tell whether any bus event has happened since it armed that field. A one-cycle interrupt pulse marks every change of the confinement flags and every newly recorded bus error.

The bus-off recovery wait itself is timed outside this block. A completion pulse, `recov_i`, returns the node to the error-active state. The inputs and outputs are plain pulses and levels with no handshake. Every pulse is taken in the cycle it is high.

Top module: `can_err_state`

## Requirements
- R1: After reset, `status_o` is 0, `errcnt_o` is 0 and `irq_o` is 0.
- R2: The transmit count appears in `errcnt_o[7:0]`.
  - An accepted error pulse with `err_tx_i`=1 adds 8 to it.
  - Otherwise, `tx_ok_i` subtracts 1 from it, but never below 0.
- R3: The receive count is held internally in the range 0..255.
  - An accepted error with `err_tx_i`=0 adds 8 to it, saturating at 255.
  - Otherwise, `rx_ok_i` subtracts 1 from it, but never below 0.
  - `errcnt_o[14:8]` shows the count, capped at 127.
  - `errcnt_o[15]` is 1 exactly when the count is 128 or more.
- R4: `status_o[6]` (warning) is 1 when either count is 96 or more.
- R5: `status_o[5]` (passive) is 1 when either count is 128 or more and the node is not bus-off.
- R6: A transmit-side error that would take the transmit count past 255 has three effects:
  - the count is set to 255;
  - `status_o[7]` (bus-off) is set;
  - from then on, every success pulse and error pulse is ignored: counts, error code and success flags do not change.
- R7: When `recov_i` pulses during bus-off, both counts go to 0 and bus-off clears. When the node is not bus-off, `recov_i` has no effect.
- R8: `status_o[2:0]` holds the last error code: 0 none, 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC, 7 unused.
  - An accepted error pulse loads its code.
  - An accepted `tx_ok_i` or `rx_ok_i` pulse loads 0.
  - An error pulse whose code is 0 or 7 is ignored entirely.
- R9: A write with `wr_en_i`=1 and `wr_data_i[2:0]`=7 loads 7 into the code field, and the field keeps 7 until the next accepted bus event.
  - Any other value in `wr_data_i[2:0]` leaves the field unchanged.
  - An accepted bus event in the same cycle takes precedence over the write.
- R10: `status_o[3]` (transmit OK) and `status_o[4]` (receive OK) are sticky flags.
  - An accepted `tx_ok_i` or `rx_ok_i` pulse sets the matching flag.
  - A write with 0 in `wr_data_i[3]` or `wr_data_i[4]` clears the matching flag; a 1 in that bit leaves it unchanged.
  - If a set and a clear arrive in the same cycle, the set wins.
- R11: `irq_o` is high for exactly one cycle, the first cycle in which the new status is visible, whenever either of these happens:
  - any of `status_o[7:5]` changes;
  - an accepted error pulse loads a code in the range 1..6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_ok_i | input | 1 | Frame transmitted without error (pulse) |
| rx_ok_i | input | 1 | Frame received without error (pulse) |
| err_v_i | input | 1 | Bus error detected (pulse) |
| err_code_i | input | 3 | Code of the detected error |
| err_tx_i | input | 1 | 1: the transmitter saw the error; 0: the receiver saw it |
| recov_i | input | 1 | Bus-off recovery wait completed (pulse) |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 5 | Write data for status bits 4:0 |
| status_o | output | 8 | Status word: bus-off, warning, passive, receive OK, transmit OK, error code |
| errcnt_o | output | 16 | Receive-passive flag, capped receive count, transmit count |
| irq_o | output | 1 | Status-change interrupt pulse |

## Verification
Every counter and flag is registered once, so a wrong internal count or flag shows up on `errcnt_o` or `status_o` one cycle after the pulse that caused it. The bench compares every field after every stimulus cycle. A mistake on the saturation or bus-off edge first becomes visible at the 32nd transmit error, or at the 32nd receive error. The sweep drives counts up to those points and down to zero again. A fault in the interrupt logic shows as a missing or extra `irq_o` pulse in the same cycle that a flag bit flips.

// File: rtl/can_err_state_pkg.sv
package can_err_state_pkg;

  typedef enum logic [2:0] {
    EC_NONE  = 3'd0,
    EC_STUFF = 3'd1,
    EC_FORM  = 3'd2,
    EC_ACK   = 3'd3,
    EC_REC1  = 3'd4,
    EC_DOM0  = 3'd5,
    EC_CRC   = 3'd6,
    EC_IDLE  = 3'd7
  } ecode_t;

  typedef struct packed {
    logic boff;
    logic warn;
    logic pass;
  } conf_t;

endpackage

// File: rtl/can_est_counter.sv
module can_est_counter #(
  parameter int W    = 8,
  parameter int STEP = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  input  logic         clr,
  input  logic         hold,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         ovf
);
  logic [W:0] sum;

  always_comb begin
    sum     = {1'b0, cnt} + (W+1)'(STEP);
    ovf     = 1'b0;
    cnt_nxt = cnt;
    if (clr) begin
      cnt_nxt = '0;
    end else if (!hold) begin
      if (inc) begin
        ovf     = sum[W];
        cnt_nxt = sum[W] ? {W{1'b1}} : sum[W-1:0];
      end else if (dec && (cnt != '0)) begin
        cnt_nxt = cnt - W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/can_est_flags.sv
module can_est_flags
  import can_err_state_pkg::*;
#(
  parameter int TX_W     = 8,
  parameter int RX_W     = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic [TX_W-1:0] tec,
  input  logic [RX_W-1:0] rec,
  input  logic            boff,
  output conf_t           fl
);
  always_comb begin
    fl.boff = boff;
    fl.warn = (tec >= TX_W'(WARN_LIM)) || (rec >= RX_W'(WARN_LIM));
    fl.pass = ((tec >= TX_W'(PASS_LIM)) || (rec >= RX_W'(PASS_LIM))) && !boff;
  end
endmodule

// File: rtl/can_est_stat.sv
module can_est_stat
  import can_err_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_acc,
  input  logic [2:0] err_code,
  input  logic       txok_acc,
  input  logic       rxok_acc,
  input  logic       wr_en,
  input  logic [4:0] wr_data,
  output ecode_t     lec,
  output logic       txok,
  output logic       rxok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lec  <= EC_NONE;
      txok <= 1'b0;
      rxok <= 1'b0;
    end else begin
      if (err_acc)                             lec <= ecode_t'(err_code);
      else if (txok_acc || rxok_acc)           lec <= EC_NONE;
      else if (wr_en && (wr_data[2:0] == 3'd7)) lec <= EC_IDLE;

      if (txok_acc)                  txok <= 1'b1;
      else if (wr_en && !wr_data[3]) txok <= 1'b0;

      if (rxok_acc)                  rxok <= 1'b1;
      else if (wr_en && !wr_data[4]) rxok <= 1'b0;
    end
  end
endmodule

// File: rtl/can_err_state.sv
module can_err_state
  import can_err_state_pkg::*;
#(
  parameter int TX_W     = 8,
  parameter int RX_W     = 8,
  parameter int STEP     = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_ok_i,
  input  logic        rx_ok_i,
  input  logic        err_v_i,
  input  logic [2:0]  err_code_i,
  input  logic        err_tx_i,
  input  logic        recov_i,
  input  logic        wr_en_i,
  input  logic [4:0]  wr_data_i,
  output logic [7:0]  status_o,
  output logic [15:0] errcnt_o,
  output logic        irq_o
);
  localparam int RF_W = RX_W - 1;

  logic            boff_q, boff_nxt;
  logic            live, code_ok, err_acc, tx_ovf, rx_ovf_unused;
  logic [TX_W-1:0] tec, tec_nxt;
  logic [RX_W-1:0] rec, rec_nxt;
  conf_t           fl_cur, fl_nxt;
  ecode_t          lec;
  logic            txok_b, rxok_b, rx_pass;
  logic [RF_W-1:0] rec_field;

  assign live    = !boff_q;
  assign code_ok = (err_code_i != 3'd0) && (err_code_i != 3'd7);
  assign err_acc = err_v_i && code_ok && live;

  can_est_counter #(.W(TX_W), .STEP(STEP)) u_tec (
    .clk(clk), .rst_n(rst_n),
    .inc(err_acc && err_tx_i), .dec(tx_ok_i),
    .clr(boff_q && recov_i), .hold(boff_q),
    .cnt(tec), .cnt_nxt(tec_nxt), .ovf(tx_ovf)
  );

  can_est_counter #(.W(RX_W), .STEP(STEP)) u_rec (
    .clk(clk), .rst_n(rst_n),
    .inc(err_acc && !err_tx_i), .dec(rx_ok_i),
    .clr(boff_q && recov_i), .hold(boff_q),
    .cnt(rec), .cnt_nxt(rec_nxt), .ovf(rx_ovf_unused)
  );

  assign boff_nxt = boff_q ? !recov_i : tx_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) boff_q <= 1'b0;
    else        boff_q <= boff_nxt;
  end

  can_est_flags #(.TX_W(TX_W), .RX_W(RX_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM))
    u_fl_cur (.tec(tec), .rec(rec), .boff(boff_q), .fl(fl_cur));

  can_est_flags #(.TX_W(TX_W), .RX_W(RX_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM))
    u_fl_nxt (.tec(tec_nxt), .rec(rec_nxt), .boff(boff_nxt), .fl(fl_nxt));

  can_est_stat u_stat (
    .clk(clk), .rst_n(rst_n),
    .err_acc(err_acc), .err_code(err_code_i),
    .txok_acc(tx_ok_i && live), .rxok_acc(rx_ok_i && live),
    .wr_en(wr_en_i), .wr_data(wr_data_i),
    .lec(lec), .txok(txok_b), .rxok(rxok_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= (fl_nxt != fl_cur) || err_acc;
  end

  assign rx_pass   = rec >= RX_W'(PASS_LIM);
  assign rec_field = rx_pass ? {RF_W{1'b1}} : rec[RF_W-1:0];
  assign status_o  = {fl_cur.boff, fl_cur.warn, fl_cur.pass, rxok_b, txok_b, lec};
  assign errcnt_o  = 16'({rx_pass, rec_field, tec});
endmodule

// File: rtl/can_err_state_chk.sv
module can_err_state_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_ok_i,
  input logic        rx_ok_i,
  input logic        err_v_i,
  input logic        recov_i,
  input logic [7:0]  status_o,
  input logic [15:0] errcnt_o,
  input logic        irq_o
);
  // R6
  boff_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] |-> errcnt_o[7:0] == 8'hFF);
  // R5
  pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5] |-> !status_o[7]);
  // R3
  rx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errcnt_o[15] |-> errcnt_o[14:8] == 7'h7F);
  // R2
  tx_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok_i && !err_v_i && !status_o[7]) |=>
      errcnt_o[7:0] == (($past(errcnt_o[7:0]) == 8'd0) ? 8'd0 : $past(errcnt_o[7:0]) - 8'd1));
  // R11
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_o[7:5]) != status_o[7:5]) |-> irq_o);
  // R10
  txok_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[3]) |-> $past(tx_ok_i));
  // R8
  code_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(status_o[2:0]) && status_o[2:0] != 3'd7) |-> $past(tx_ok_i || rx_ok_i || err_v_i));
  // R7
  recov_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[7]) |-> $past(recov_i));
endmodule

bind can_err_state can_err_state_chk u_chk (.*);

// File: tb/tb_can_err_state.sv
module tb_can_err_state;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_ok_i = 0, rx_ok_i = 0, err_v_i = 0, err_tx_i = 0, recov_i = 0, wr_en_i = 0;
  logic [2:0]  err_code_i = 0;
  logic [4:0]  wr_data_i = 0;
  logic [7:0]  status_o;
  logic [15:0] errcnt_o;
  logic        irq_o;

  int compared = 0, mismatched = 0;
  int m_tec = 0, m_rec = 0, m_lec = 0;
  bit m_boff = 0, m_txb = 0, m_rxb = 0, m_irq = 0;

  always #10 clk = ~clk;

  can_err_state dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit [2:0] mflags();
    bit warn, pass;
    warn = (m_tec >= 96) || (m_rec >= 96);
    pass = ((m_tec >= 128) || (m_rec >= 128)) && !m_boff;
    return {m_boff, warn, pass};
  endfunction

  task automatic check_all();
    bit [2:0] f;
    f = mflags();
    chk("R2 tx count", int'(errcnt_o[7:0]), m_tec);
    chk("R3 rx field", int'(errcnt_o[14:8]), (m_rec > 127) ? 127 : m_rec);
    chk("R3 rx passive", int'(errcnt_o[15]), int'(m_rec >= 128));
    chk("R6 bus-off", int'(status_o[7]), int'(f[2]));
    chk("R4 warning", int'(status_o[6]), int'(f[1]));
    chk("R5 passive", int'(status_o[5]), int'(f[0]));
    chk("R10 rx ok", int'(status_o[4]), int'(m_rxb));
    chk("R10 tx ok", int'(status_o[3]), int'(m_txb));
    chk("R8/R9 code", int'(status_o[2:0]), m_lec);
    chk("R11 irq", int'(irq_o), int'(m_irq));
  endtask

  task automatic ev(input bit txok, input bit rxok, input bit errv, input int code,
                    input bit side, input bit recov, input bit wr, input int wdata);
    bit acc, eok;
    bit [2:0] f0;
    @(negedge clk);
    tx_ok_i = txok; rx_ok_i = rxok; err_v_i = errv; err_code_i = code[2:0];
    err_tx_i = side; recov_i = recov; wr_en_i = wr; wr_data_i = wdata[4:0];
    f0  = mflags();
    acc = !m_boff;
    eok = errv && code >= 1 && code <= 6;
    if (m_boff) begin
      if (recov) begin m_tec = 0; m_rec = 0; m_boff = 0; end
    end else begin
      if (eok && side) begin
        if (m_tec + 8 > 255) begin m_tec = 255; m_boff = 1; end else m_tec += 8;
      end else if (txok && m_tec > 0) m_tec--;
      if (eok && !side) m_rec = (m_rec + 8 > 255) ? 255 : m_rec + 8;
      else if (rxok && m_rec > 0) m_rec--;
    end
    if (acc && eok) m_lec = code;
    else if (acc && (txok || rxok)) m_lec = 0;
    else if (wr && wdata[2:0] == 3'd7) m_lec = 7;
    if (acc && txok) m_txb = 1; else if (wr && !wdata[3]) m_txb = 0;
    if (acc && rxok) m_rxb = 1; else if (wr && !wdata[4]) m_rxb = 0;
    m_irq = (mflags() != f0) || (acc && eok);
    @(negedge clk);
    tx_ok_i = 0; rx_ok_i = 0; err_v_i = 0; recov_i = 0; wr_en_i = 0;
    check_all();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 status", int'(status_o), 0);
    chk("R1 errcnt", int'(errcnt_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R8: every code on both sides, codes 0 and 7 ignored
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 8; c++) ev(0, 0, 1, c, s[0], 0, 0, 0);
    // R7: recovery outside bus-off has no effect
    ev(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 no effect", int'(errcnt_o), (48 << 8) | 48);
    // R9: sentinel arm and hold; other values leave the field
    ev(0, 0, 0, 0, 0, 0, 1, 5'b11111);
    ev(0, 0, 0, 0, 0, 0, 1, 5'b11010);
    chk("R9 held", int'(status_o[2:0]), 7);
    ev(1, 0, 0, 0, 0, 0, 1, 5'b11111);
    ev(0, 1, 0, 0, 0, 0, 0, 0);

    // R3/R4/R5: receive ramp to saturation and back down
    for (int i = 0; i < 34; i++) ev(0, 0, 1, (i % 6) + 1, 0, 0, 0, 0);
    for (int i = 0; i < 260; i++) ev(0, 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) ev(1, 0, 0, 0, 0, 0, 0, 0);

    // R2/R6: transmit ramp into bus-off with interleaved successes
    for (int i = 0; i < 40 && !m_boff; i++) begin
      ev(0, 0, 1, (i % 6) + 1, 1, 0, 0, 0);
      if (i % 5 == 4) ev(1, 0, 0, 0, 0, 0, 0, 0);
    end
    chk("R6 entered", int'(status_o[7]), 1);
    ev(0, 0, 0, 0, 0, 0, 1, 5'b00111);
    ev(1, 0, 0, 0, 0, 0, 0, 0);
    ev(0, 1, 0, 0, 0, 0, 0, 0);
    ev(0, 0, 1, 2, 0, 0, 0, 0);
    ev(0, 0, 1, 3, 1, 0, 0, 0);
    chk("R6 ignored", int'(status_o[4:0]), 7);
    chk("R6 counts frozen", int'(errcnt_o), 255);
    ev(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 recovered", int'({status_o[7], errcnt_o}), 0);

    // R10/R9: sweep every write value with both sticky bits set first
    for (int w = 0; w < 32; w++) begin
      ev(1, 1, 0, 0, 0, 0, 0, 0);
      ev(0, 0, 0, 0, 0, 0, 1, w);
    end
    // R10: set wins over clear in the same cycle; R9 event wins over write
    ev(1, 0, 0, 0, 0, 0, 1, 5'b00111);
    ev(0, 0, 1, 4, 0, 0, 1, 5'b00111);
    chk("R9 event wins", int'(status_o[2:0]), 4);

    summary();
    $finish;
  end
endmodule